// File: doc/BRIEF.md
# Power-Down and Warm-Start Sequencer

This block sequences entry into and exit from a RAM-retaining sleep state for a small 4-bit microcontroller core. The core hands it one strobe per retired instruction, tagged as an arm-sleep command, a sleep command, a flag-test command or anything else. A sleep command stops the oscillator only if the instruction retired just before it was the arm command. Otherwise the sleep command does nothing and the core keeps running. On entry the block presets the stack pointer to its top level. It sets a sticky power-down flag and marks the watchdog as running in sleep, so that a watchdog timeout can still bring the chip back.

Two kinds of event end sleep or restart the core. An external wakeup ends sleep with the flag left at 1, which is a warm start. The reset pin, a watchdog timeout or a low-voltage detect clears the flag, which is a cold start. Both kinds restart the oscillator and hold the CPU for a fixed stabilisation count. The block then releases the CPU with a one-cycle restart pulse that carries the vector page 0, address 0. The core uses that pulse to reload its non-retained registers. Software runs the flag-test command to tell the two starts apart. The block raises a skip request when the flag is set.

All pins are plain control and status signals with no data stream, so no valid/ready handshake exists. `rst_n` is the power-on reset and has the same effect as a cold start with the sequencer idle.

Top module: `pwrdn_ctl`

## Requirements
- R1: The sleep state is entered only when a retired sleep command (`op_poff`) directly follows a retired arm command (`op_arm`). Cycles with `ins_ret` low between the two do not break the pair, and a second arm keeps the block armed.
- R2: A sleep command without a preceding arm has no effect: `osc_en` stays 1, `cpu_hold` stays 0 and `pd_flag` keeps its value.
- R3: Any retired instruction other than the arm or sleep command (a plain instruction or a flag test) clears the armed state, so a following sleep command is ignored.
- R4: `osc_en` goes to 0 in the cycle after the committing sleep command. It returns to 1 in the cycle after a wakeup or cold-start source is seen in sleep.
- R5: A wakeup (`wake_in`) in sleep holds the CPU (`cpu_hold`=1) with the oscillator on for exactly STAB_CYC cycles. The block then drops `cpu_hold` and pulses `cpu_restart` for one cycle, and `pd_flag` stays 1.
- R6: `rst_pin`, `wdt_expire` or `lvd_det` in any state clears `pd_flag` in the next cycle. It also restarts the stabilisation count with `cpu_hold`=1, and the same release sequence as R5 follows.
- R7: A cold-start source wins over a wakeup or a committing sleep command in the same cycle: the flag ends at 0 and sleep is not entered.
- R8: `sp_load` pulses for one cycle, the first cycle of sleep, with `sp_val` = SP_DEPTH-1 (7 by default).
- R9: `skip` is 1 in a cycle where a flag-test command (`op_tst`) retires while `pd_flag` is 1, and 0 at all other times.
- R10: `wdt_keep` is 1 exactly while the sleep state holds (oscillator stopped).
- R11: After power-on reset `pd_flag`=0, `osc_en`=1, `cpu_hold`=0. `rst_page` and `rst_addr` are always 0.
- R12: `wake_in` outside the sleep state has no effect on `cpu_hold`, `osc_en` or `pd_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Power-on reset, active low |
| ins_ret | input | 1 | An instruction retires this cycle |
| op_arm | input | 1 | Retiring instruction is the arm-sleep command |
| op_poff | input | 1 | Retiring instruction is the sleep command |
| op_tst | input | 1 | Retiring instruction tests the power-down flag |
| wake_in | input | 1 | External wakeup request |
| rst_pin | input | 1 | Reset pin asserted |
| wdt_expire | input | 1 | Watchdog timeout |
| lvd_det | input | 1 | Low-voltage detect |
| osc_en | output | 1 | Oscillator enable |
| cpu_hold | output | 1 | Hold the CPU |
| cpu_restart | output | 1 | One-cycle restart and register reload pulse |
| rst_page | output | PAGE_W | Restart page (0) |
| rst_addr | output | ADDR_W | Restart address (0) |
| sp_load | output | 1 | Stack-pointer preset strobe |
| sp_val | output | SP_W | Stack-pointer preset value |
| pd_flag | output | 1 | Power-down flag (1 = warm start) |
| skip | output | 1 | Skip request for the flag-test command |
| wdt_keep | output | 1 | Watchdog kept running in sleep |

## Verification
On every cycle the assertions check several local rules. The oscillator drops after a commit, and any drop must follow a commit. A cold source clears the flag and holds the CPU. Without a cold source or a commit, the flag keeps its value. The restart and stack-preset strobes last one cycle, and a stray wakeup while running never raises the hold. The bench scenarios cover the ordering rules that no single-cycle property can capture. These include arm-then-sleep pairs with idle gaps or intervening instructions, the exact 16-cycle stabilisation window, and every combination of the three cold sources with wakeup while asleep.

// File: rtl/pwrdn_pkg.sv
package pwrdn_pkg;
  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_DOWN = 2'd1,
    ST_STAB = 2'd2
  } pd_st_t;
endpackage

// File: rtl/pd_arm.sv
module pd_arm (
  input  logic clk,
  input  logic rst_n,
  input  logic ins_ret,
  input  logic op_arm,
  input  logic op_poff,
  input  logic cold,
  input  logic running,
  output logic commit
);
  logic armed_q;

  // Any retired instruction rewrites the latch; idle cycles keep it.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        armed_q <= 1'b0;
    else if (cold)     armed_q <= 1'b0;
    else if (ins_ret)  armed_q <= op_arm & running;
  end

  assign commit = running & ins_ret & op_poff & armed_q & ~cold;

  // R3: a non-arm retirement leaves the block disarmed next cycle
  a_r3_disarm: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_ret && !op_arm) |=> !commit);
endmodule

// File: rtl/pd_flag.sv
module pd_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic commit,
  input  logic cold,
  input  logic ins_ret,
  input  logic op_tst,
  output logic flag,
  output logic skip
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag <= 1'b0;
    else if (cold)    flag <= 1'b0;
    else if (commit)  flag <= 1'b1;
  end

  assign skip = ins_ret & op_tst & flag;

  a_r7_cold_clears: assert property (@(posedge clk) disable iff (!rst_n)
    cold |=> !flag);
  a_r5_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (!cold && !commit) |=> (flag == $past(flag)));
endmodule

// File: rtl/pd_seq.sv
module pd_seq
  import pwrdn_pkg::*;
#(
  parameter int STAB_CYC = 16
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   commit,
  input  logic   cold,
  input  logic   wake,
  output pd_st_t state,
  output logic   restart,
  output logic   sp_load
);
  localparam int CW = (STAB_CYC > 1) ? $clog2(STAB_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(STAB_CYC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_RUN;
      cnt_q   <= '0;
      restart <= 1'b0;
      sp_load <= 1'b0;
    end else begin
      restart <= 1'b0;
      sp_load <= 1'b0;
      if (cold) begin
        state <= ST_STAB;
        cnt_q <= '0;
      end else begin
        case (state)
          ST_RUN: if (commit) begin
            state   <= ST_DOWN;
            sp_load <= 1'b1;
          end
          ST_DOWN: if (wake) begin
            state <= ST_STAB;
            cnt_q <= '0;
          end
          ST_STAB: begin
            if (cnt_q == LAST) begin
              state   <= ST_RUN;
              restart <= 1'b1;
            end
            cnt_q <= cnt_q + 1'b1;
          end
          default: state <= ST_RUN;
        endcase
      end
    end
  end

  a_r6_cold_stab: assert property (@(posedge clk) disable iff (!rst_n)
    cold |=> (state == ST_STAB));
  a_r5_restart_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !restart);
  a_r8_sp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    sp_load |=> !sp_load);
  a_r5_restart_from_stab: assert property (@(posedge clk) disable iff (!rst_n)
    restart |-> ($past(state) == ST_STAB));
endmodule

// File: rtl/pwrdn_ctl.sv
module pwrdn_ctl
  import pwrdn_pkg::*;
#(
  parameter int STAB_CYC = 16,
  parameter int SP_DEPTH = 8,
  parameter int PAGE_W   = 6,
  parameter int ADDR_W   = 7,
  localparam int SP_W    = (SP_DEPTH > 1) ? $clog2(SP_DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ins_ret,
  input  logic              op_arm,
  input  logic              op_poff,
  input  logic              op_tst,
  input  logic              wake_in,
  input  logic              rst_pin,
  input  logic              wdt_expire,
  input  logic              lvd_det,
  output logic              osc_en,
  output logic              cpu_hold,
  output logic              cpu_restart,
  output logic [PAGE_W-1:0] rst_page,
  output logic [ADDR_W-1:0] rst_addr,
  output logic              sp_load,
  output logic [SP_W-1:0]   sp_val,
  output logic              pd_flag,
  output logic              skip,
  output logic              wdt_keep
);
  pd_st_t st;
  logic   cold, commit, running;

  assign cold    = rst_pin | wdt_expire | lvd_det;
  assign running = (st == ST_RUN);

  pd_arm u_arm (
    .clk(clk), .rst_n(rst_n), .ins_ret(ins_ret), .op_arm(op_arm),
    .op_poff(op_poff), .cold(cold), .running(running), .commit(commit)
  );

  pd_flag u_flag (
    .clk(clk), .rst_n(rst_n), .commit(commit), .cold(cold),
    .ins_ret(ins_ret), .op_tst(op_tst), .flag(pd_flag), .skip(skip)
  );

  pd_seq #(.STAB_CYC(STAB_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .commit(commit), .cold(cold), .wake(wake_in),
    .state(st), .restart(cpu_restart), .sp_load(sp_load)
  );

  assign osc_en   = (st != ST_DOWN);
  assign cpu_hold = (st != ST_RUN);
  assign wdt_keep = (st == ST_DOWN);
  assign rst_page = '0;
  assign rst_addr = '0;
  assign sp_val   = SP_W'(SP_DEPTH - 1);

  a_r4_osc_off: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !osc_en);
  a_r1_entry_needs_commit: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(osc_en) |-> $past(commit));
  a_r8_sp_on_entry: assert property (@(posedge clk) disable iff (!rst_n)
    sp_load |-> (wdt_keep && $past(commit)));
  a_r12_wake_running: assert property (@(posedge clk) disable iff (!rst_n)
    (running && wake_in && !cold && !commit) |=> !cpu_hold);
  a_r6_cold_hold: assert property (@(posedge clk) disable iff (!rst_n)
    cold |=> (cpu_hold && osc_en));
endmodule

// File: tb/sim_pwrdn_ctl.sv
module sim_pwrdn_ctl;
  localparam int CLK_P = 10;
  localparam int STAB  = 16;

  logic clk = 0, rst_n = 0;
  logic ins_ret = 0, op_arm = 0, op_poff = 0, op_tst = 0;
  logic wake_in = 0, rst_pin = 0, wdt_expire = 0, lvd_det = 0;
  logic osc_en, cpu_hold, cpu_restart, sp_load, pd_flag, skip, wdt_keep;
  logic [5:0] rst_page;
  logic [6:0] rst_addr;
  logic [2:0] sp_val;
  int n_chk = 0, n_bad = 0;

  always #(CLK_P/2) clk = ~clk;

  pwrdn_ctl u0 (.*);

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  // one retired instruction: kind 0 plain, 1 arm, 2 sleep, 3 flag test
  task automatic instr(int kind);
    ins_ret = 1; op_arm = (kind == 1); op_poff = (kind == 2); op_tst = (kind == 3);
    step();
    ins_ret = 0; op_arm = 0; op_poff = 0; op_tst = 0;
  endtask

  task automatic cold_restart();
    rst_pin = 1; step(); rst_pin = 0;
    repeat (STAB) step();
  endtask

  task automatic go_down();
    instr(1); instr(2);
  endtask

  initial begin
    #(CLK_P*2000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #3; rst_n = 0; step(); rst_n = 1; step();
    chk("R11 flag", pd_flag, 0); chk("R11 osc", osc_en, 1);
    chk("R11 hold", cpu_hold, 0); chk("R11 vector", {rst_page, rst_addr}, 0);

    // R2: sleep alone ignored
    instr(2); chk("R2 osc", osc_en, 1); chk("R2 hold", cpu_hold, 0);
    chk("R2 flag", pd_flag, 0);

    // R12: wake while running ignored
    wake_in = 1; step(); wake_in = 0;
    chk("R12 hold", cpu_hold, 0); chk("R12 flag", pd_flag, 0);

    // R1/R3 sweep: arm, k idle cycles, optional intervening instruction, sleep
    for (int k = 0; k < 3; k++) begin
      for (int mid = -1; mid < 4; mid++) begin
        if (mid == 2) continue;
        instr(1);
        repeat (k) step();
        if (mid >= 0) instr(mid);
        instr(2);
        if (mid == -1 || mid == 1) begin
          chk("R1 entered osc", osc_en, 0);
          chk("R10 wdt_keep", wdt_keep, 1);
          cold_restart(); step();
        end else begin
          chk("R3 no entry osc", osc_en, 1);
          chk("R3 no entry hold", cpu_hold, 0);
        end
      end
    end

    // R4/R5/R8 warm start timing
    instr(1);
    ins_ret = 1; op_poff = 1; step(); ins_ret = 0; op_poff = 0;
    chk("R4 osc low", osc_en, 0); chk("R8 sp_load", sp_load, 1);
    chk("R8 sp_val", sp_val, 7); chk("R5 flag set", pd_flag, 1);
    step(); chk("R8 sp pulse", sp_load, 0); chk("R4 still low", osc_en, 0);
    wake_in = 1; step(); wake_in = 0;
    chk("R4 osc back", osc_en, 1); chk("R5 hold", cpu_hold, 1);
    chk("R10 wdt off", wdt_keep, 0);
    repeat (STAB-1) step();
    chk("R5 hold at 15", cpu_hold, 1); chk("R5 no restart yet", cpu_restart, 0);
    step(); chk("R5 released", cpu_hold, 0); chk("R5 restart", cpu_restart, 1);
    chk("R5 warm flag", pd_flag, 1);
    step(); chk("R5 restart pulse", cpu_restart, 0);
    ins_ret = 1; op_tst = 1; #1; chk("R9 skip set", skip, 1);
    step(); ins_ret = 0; op_tst = 0; #1; chk("R9 skip idle", skip, 0);

    // R6/R7 sweep over cold sources and wakeup while asleep
    for (int s = 0; s < 8; s++) begin
      for (int w = 0; w < 2; w++) begin
        go_down();
        rst_pin = s[0]; wdt_expire = s[1]; lvd_det = s[2]; wake_in = w[0];
        step();
        rst_pin = 0; wdt_expire = 0; lvd_det = 0; wake_in = 0;
        if (s == 0 && w == 0) begin
          chk("R4 stays down", osc_en, 0); chk("R5 flag kept", pd_flag, 1);
          cold_restart(); step();
        end else begin
          chk("R6 hold", cpu_hold, 1); chk("R4 osc on", osc_en, 1);
          chk(s != 0 ? "R7 cold wins" : "R5 warm", pd_flag, (s == 0) ? 1 : 0);
          repeat (STAB) step();
          chk("R6 released", cpu_hold, 0);
          step();
        end
      end
    end

    // R9: flag clear means no skip
    ins_ret = 1; op_tst = 1; #1; chk("R9 skip clear", skip, 0);
    step(); ins_ret = 0; op_tst = 0;

    // R7: cold with committing sleep in same cycle
    instr(1);
    ins_ret = 1; op_poff = 1; lvd_det = 1; step();
    ins_ret = 0; op_poff = 0; lvd_det = 0;
    chk("R7 no sleep", osc_en, 1); chk("R7 flag", pd_flag, 0);
    chk("R6 hold", cpu_hold, 1);
    repeat (STAB) step();
    chk("R6 restart", cpu_restart, 1);

    // R6: cold while running
    step(); wdt_expire = 1; step(); wdt_expire = 0;
    chk("R6 run cold hold", cpu_hold, 1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule